// File: doc/BRIEF.md
# Latched Status Interrupt Register Bank

This block gathers the condition signals of one transceiver port and turns them into readable status and a single interrupt request. Three event conditions are watched: the receive clock recovery loop losing lock, a fault from the transmit driver monitor, and a performance update being complete. The update is complete when the software update request is high and every one of the update-done handshakes is high. Two further inputs report activity on the receive line clock and on the transmit input clock.

Every input crosses into the register clock domain through a two-flop synchronizer. The synchronized event levels can be read live. A sticky register records the rising edges of the events and any sighting of clock activity. Software clears a sticky bit by writing 1 to it. An enable register selects which sticky event bits feed a per-port summary flag. The interrupt pin is that summary flag gated by a global port enable. Software reads and writes the three registers through a plain 16-bit register port with a byte address.

Top module: `portStatusBank`

## Requirements
- R1: After reset the sticky, enable and live registers read 0x0000, and portSummary and intOut are low.
- R2: The live register at 052h shows the synchronized levels two cycles after an input change: bit 2 is the driver fault, bit 1 is loss of lock (1 = not locked), and bit 0 is update-complete, which is updReqIn AND all bits of updDoneIn.
- R3: Update-complete reads 0 while updReqIn is low, and also while any updDoneIn bit is low, even if all the others are high.
- R4: Sticky bits 2, 1 and 0 at 054h set one cycle after a synchronized low-to-high transition of the matching live bit. A level that stays high does not set them again once they have been cleared.
- R5: Sticky bit 7 sets while the synchronized rxClkAct is high. Sticky bit 6 sets while the synchronized txClkAct is high.
- R6: A write to 054h clears each sticky bit whose data bit is 1. Data bits that are 0 leave the register unchanged.
- R7: When a new set condition and a write-1 clear hit the same sticky bit in the same cycle, the bit stays 1.
- R8: The enable register at 056h stores data bits 2:0 (bit 2 driver fault, bit 1 loss of lock, bit 0 update-complete). All its other bits read 0.
- R9: portSummary is high exactly when some sticky bit in 2:0 and its enable bit are both 1. intOut equals portSummary AND globalIntEn, and it is level-based.
- R10: An event input that is already high at reset release does not produce a sticky bit.
- R11: Writes to any other address change nothing. Reads of other addresses return 0. Sticky bits 15:8 and 5:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr (combinational) |
| lolIn | input | 1 | Receive clock recovery loss of lock |
| drvFaultIn | input | 1 | Transmit driver monitor fault |
| updReqIn | input | 1 | Software performance update request |
| updDoneIn | input | NUM_UPD | Update-done handshakes of the counter groups |
| rxClkAct | input | 1 | Receive line clock activity indication |
| txClkAct | input | 1 | Transmit input clock activity indication |
| globalIntEn | input | 1 | Global enable for this port's interrupt |
| portSummary | output | 1 | OR of enabled sticky event bits |
| intOut | output | 1 | Active-high interrupt request |

## Verification
The collision that matters is a write-1 clear of a sticky bit that arrives in the same cycle as a fresh rising edge on that bit. The bench provokes it by first setting the loss-of-lock bit and dropping the input. It then raises the input again and places the clear write in the cycle where the synchronized edge lands, two edges after the input is sampled. The bit must still read 1 afterwards, and the interrupt must stay asserted. A behavioural model, compared on every clock, judges both the collision and the ordinary clear one cycle apart.

// File: rtl/psbPkg.sv
package psbPkg;

  localparam int DATA_W   = 16;
  localparam int NUM_EVT  = 3;   // driver fault, loss of lock, update complete
  localparam int NUM_ACT  = 2;   // receive clock, transmit clock

  // sticky register bit positions
  localparam int POS_RXACT = 7;
  localparam int POS_TXACT = 6;

  typedef struct packed {
    logic                armed;    // edge detection allowed
    logic                clrEn;    // write-1 clear of sticky register
    logic                ieWrEn;   // enable register write
    logic [7:0]          wrByte;   // low byte of write data
    logic [2:0]          rdSel;    // one-hot {enable, sticky, live}
  } psbStrobe_t;

endpackage

// File: rtl/psbSync.sv
module psbSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= '0;
        else       stg[g] <= d;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= '0;
        else       stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/psbControl.sv
module psbControl
  import psbPkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] OFS_LIVE  = 8'h52,
  parameter logic [ADDR_W-1:0] OFS_LATCH = 8'h54,
  parameter logic [ADDR_W-1:0] OFS_IE    = 8'h56,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrByte,
  output psbStrobe_t        strobe
);

  localparam int ARM_AT = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(ARM_AT + 1);

  logic [CNT_W-1:0] armCnt;
  logic hitLive, hitLatch, hitIe;

  // count filled synchronizer stages plus the previous-value register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           armCnt <= '0;
    else if (armCnt != CNT_W'(ARM_AT))   armCnt <= armCnt + 1'b1;
  end

  always_comb begin
    hitLive  = (busAddr == OFS_LIVE);
    hitLatch = (busAddr == OFS_LATCH);
    hitIe    = (busAddr == OFS_IE);

    strobe.armed  = (armCnt == CNT_W'(ARM_AT));
    strobe.clrEn  = busWrEn && hitLatch;
    strobe.ieWrEn = busWrEn && hitIe;
    strobe.wrByte = busWrByte;
    strobe.rdSel  = {hitIe, hitLatch, hitLive};
  end

endmodule

// File: rtl/psbDatapath.sv
module psbDatapath
  import psbPkg::*;
#(
  parameter int NUM_UPD     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lolIn,
  input  logic                drvFaultIn,
  input  logic                updReqIn,
  input  logic [NUM_UPD-1:0]  updDoneIn,
  input  logic                rxClkAct,
  input  logic                txClkAct,
  input  psbStrobe_t          strobe,
  output logic [NUM_EVT-1:0]  evtSync,
  output logic [NUM_EVT-1:0]  evtLatch,
  output logic [NUM_EVT-1:0]  ieQ,
  output logic                summary,
  output logic [DATA_W-1:0]   rdData
);

  localparam int RAW_W = NUM_EVT + NUM_ACT;

  logic               updComplete;
  logic [RAW_W-1:0]   rawIn, syncOut;
  logic [NUM_ACT-1:0] actSync, actLatch;
  logic [NUM_EVT-1:0] evtPrev, edgeHit, evtClr;
  logic [NUM_ACT-1:0] actClr;
  logic [DATA_W-1:0]  liveWord, latchWord, ieWord;

  assign updComplete = updReqIn & (&updDoneIn);
  assign rawIn       = {txClkAct, rxClkAct, drvFaultIn, lolIn, updComplete};

  psbSync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .d    (rawIn),
    .q    (syncOut)
  );

  assign evtSync = syncOut[NUM_EVT-1:0];
  assign actSync = syncOut[RAW_W-1:NUM_EVT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= '0;
    else       evtPrev <= evtSync;
  end

  assign edgeHit = evtSync & ~evtPrev & {NUM_EVT{strobe.armed}};
  assign evtClr  = strobe.clrEn ? strobe.wrByte[NUM_EVT-1:0] : '0;
  assign actClr  = strobe.clrEn ? {strobe.wrByte[POS_TXACT], strobe.wrByte[POS_RXACT]} : '0;

  // sticky bits: set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtLatch <= '0;
      actLatch <= '0;
    end else begin
      evtLatch <= (evtLatch & ~evtClr) | edgeHit;
      actLatch <= (actLatch & ~actClr) | actSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ieQ <= '0;
    else if (strobe.ieWrEn) ieQ <= strobe.wrByte[NUM_EVT-1:0];
  end

  assign summary = |(evtLatch & ieQ);

  always_comb begin
    liveWord  = '0;
    liveWord[NUM_EVT-1:0] = evtSync;
    latchWord = '0;
    latchWord[NUM_EVT-1:0] = evtLatch;
    latchWord[POS_RXACT]   = actLatch[0];
    latchWord[POS_TXACT]   = actLatch[1];
    ieWord    = '0;
    ieWord[NUM_EVT-1:0] = ieQ;

    rdData = '0;
    if (strobe.rdSel[0]) rdData = liveWord;
    if (strobe.rdSel[1]) rdData = latchWord;
    if (strobe.rdSel[2]) rdData = ieWord;
  end

endmodule

// File: rtl/portStatusBank.sv
module portStatusBank
  import psbPkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] OFS_LIVE    = 8'h52,
  parameter logic [ADDR_W-1:0] OFS_LATCH   = 8'h54,
  parameter logic [ADDR_W-1:0] OFS_IE      = 8'h56,
  parameter int                NUM_UPD     = 4,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [15:0]        busWrData,
  output logic [15:0]        busRdData,
  input  logic               lolIn,
  input  logic               drvFaultIn,
  input  logic               updReqIn,
  input  logic [NUM_UPD-1:0] updDoneIn,
  input  logic               rxClkAct,
  input  logic               txClkAct,
  input  logic               globalIntEn,
  output logic               portSummary,
  output logic               intOut
);

  psbStrobe_t         strobe;
  logic [NUM_EVT-1:0] evtSync, evtLatch, ieQ;

  psbControl #(
    .ADDR_W(ADDR_W), .OFS_LIVE(OFS_LIVE), .OFS_LATCH(OFS_LATCH),
    .OFS_IE(OFS_IE), .SYNC_STAGES(SYNC_STAGES)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrByte (busWrData[7:0]),
    .strobe    (strobe)
  );

  psbDatapath #(.NUM_UPD(NUM_UPD), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .lolIn      (lolIn),
    .drvFaultIn (drvFaultIn),
    .updReqIn   (updReqIn),
    .updDoneIn  (updDoneIn),
    .rxClkAct   (rxClkAct),
    .txClkAct   (txClkAct),
    .strobe     (strobe),
    .evtSync    (evtSync),
    .evtLatch   (evtLatch),
    .ieQ        (ieQ),
    .summary    (portSummary),
    .rdData     (busRdData)
  );

  assign intOut = portSummary & globalIntEn;

endmodule

// File: rtl/psbChecker.sv
module psbChecker (
  input logic        clk,
  input logic        rstN,
  input logic        clrEn,
  input logic        ieWrEn,
  input logic [2:0]  evtSync,
  input logic [2:0]  evtLatch,
  input logic [2:0]  ieQ,
  input logic [15:0] busRdData,
  input logic        globalIntEn,
  input logic        intOut
);

  AST_INT_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> globalIntEn); // R9

  AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((evtLatch & ieQ) != 3'b000)); // R9

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrEn) |-> ((evtLatch & $past(evtLatch)) == $past(evtLatch))); // R6

  AST_SET_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((evtLatch & ~$past(evtLatch) & ~$past(evtSync)) == 3'b000)); // R4

  AST_IE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ieWrEn) |-> $stable(ieQ)); // R8

  AST_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[15:8] == 8'h00); // R11

endmodule

bind portStatusBank psbChecker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .clrEn       (strobe.clrEn),
  .ieWrEn      (strobe.ieWrEn),
  .evtSync     (evtSync),
  .evtLatch    (evtLatch),
  .ieQ         (ieQ),
  .busRdData   (busRdData),
  .globalIntEn (globalIntEn),
  .intOut      (intOut)
);

// File: tb/portStatusBank_tb.sv
module portStatusBank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_UPD    = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [7:0]         busAddr = 8'h54;
  logic               busWrEn = 1'b0;
  logic [15:0]        busWrData = '0;
  logic [15:0]        busRdData;
  logic               lolIn = 1'b0, drvFaultIn = 1'b0, updReqIn = 1'b0;
  logic [NUM_UPD-1:0] updDoneIn = '0;
  logic               rxClkAct = 1'b0, txClkAct = 1'b0, globalIntEn = 1'b0;
  logic               portSummary, intOut;

  int    checks = 0, fails = 0;
  bit    finished = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  portStatusBank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .lolIn(lolIn),
    .drvFaultIn(drvFaultIn), .updReqIn(updReqIn), .updDoneIn(updDoneIn),
    .rxClkAct(rxClkAct), .txClkAct(txClkAct), .globalIntEn(globalIntEn),
    .portSummary(portSummary), .intOut(intOut)
  );

  // ---------------- behavioural reference model ----------------
  int         edgeNo;
  logic [4:0] hist [$];      // samples {tx,rx,drv,lol,upd}, newest first
  logic [7:0] mSticky;
  logic [2:0] mIe;

  function automatic logic [4:0] sampleAt(int back);
    return (back < hist.size()) ? hist[back] : 5'b0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      edgeNo = 0; hist = {}; mSticky = 8'h00; mIe = 3'b000;
    end else begin
      logic [4:0] cur, twoBack, threeBack;
      logic [2:0] rise;
      logic [7:0] setMask;
      edgeNo++;
      cur = {txClkAct, rxClkAct, drvFaultIn, lolIn, updReqIn && (&updDoneIn)};
      twoBack   = sampleAt(1);
      threeBack = sampleAt(2);
      rise = (edgeNo >= 4) ? (twoBack[2:0] & ~threeBack[2:0]) : 3'b000;
      setMask = {twoBack[3], twoBack[4], 3'b000, rise};
      if (busWrEn && busAddr == 8'h54) mSticky = mSticky & ~(busWrData[7:0] & 8'hC7);
      mSticky = mSticky | setMask;
      if (busWrEn && busAddr == 8'h56) mIe = busWrData[2:0];
      hist.push_front(cur);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  function automatic logic [15:0] modelRead();
    logic [4:0] s;
    s = sampleAt(1);
    if (!rstN) return 16'h0;
    case (busAddr)
      8'h52:   return {13'b0, s[2:0]};
      8'h54:   return {8'h00, mSticky};
      8'h56:   return {13'b0, mIe};
      default: return 16'h0;
    endcase
  endfunction

  // every-cycle comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [15:0] er;
      logic        es, ei;
      er = modelRead();
      es = |(mSticky[2:0] & mIe);
      ei = es & globalIntEn;
      checks++;
      if (busRdData !== er || portSummary !== es || intOut !== ei) begin
        fails++;
        $display("FAIL %s: rd=%h sum=%b int=%b expected rd=%h sum=%b int=%b",
                 phase, busRdData, portSummary, intOut, er, es, ei);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic busWrite(logic [7:0] a, logic [15:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic expectRead(string tag, logic [7:0] a, logic [15:0] exp);
    busAddr = a;
    @(negedge clk);
    checks++;
    if (busRdData !== exp) begin
      fails++;
      $display("FAIL %s: addr %h read %h expected %h", tag, a, busRdData, exp);
    end
    step();
  endtask

  task automatic expectInt(string tag, logic exp);
    @(negedge clk);
    checks++;
    if (intOut !== exp) begin
      fails++;
      $display("FAIL %s: intOut %b expected %b", tag, intOut, exp);
    end
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10: loss of lock already high across reset
    lolIn = 1'b1;
    step(3);
    rstN = 1'b1;
    phase = "R1";
    expectRead("R1", 8'h54, 16'h0000);
    expectRead("R1", 8'h56, 16'h0000);
    phase = "R10";
    step(6);
    expectRead("R10", 8'h54, 16'h0000);
    expectRead("R2", 8'h52, 16'h0002);
    lolIn = 1'b0; step(4);

    phase = "R8";
    busWrite(8'h56, 16'hFFFF);
    expectRead("R8", 8'h56, 16'h0007);
    busWrite(8'h56, 16'h0002);
    expectRead("R8", 8'h56, 16'h0002);

    phase = "R4";
    busAddr = 8'h54;
    drvFaultIn = 1'b1; step(4);
    expectRead("R4", 8'h54, 16'h0004);
    busWrite(8'h54, 16'h0004);
    step(5);
    expectRead("R4", 8'h54, 16'h0000);
    drvFaultIn = 1'b0; step(3);

    phase = "R9";
    globalIntEn = 1'b1;
    lolIn = 1'b1; step(4);
    expectInt("R9", 1'b1);
    globalIntEn = 1'b0; #1;
    expectInt("R9", 1'b0);
    globalIntEn = 1'b1;
    step(3);
    expectInt("R9", 1'b1);
    lolIn = 1'b0; step(4);

    phase = "R6";
    busWrite(8'h54, 16'h0000);
    expectRead("R6", 8'h54, 16'h0002);

    phase = "R7";
    lolIn = 1'b1; step();          // sampled at the next edge
    step();
    busAddr = 8'h54; busWrData = 16'h0002; busWrEn = 1'b1;
    step();                        // clear meets the synchronized rise
    busWrEn = 1'b0; busWrData = '0;
    expectRead("R7", 8'h54, 16'h0002);
    expectInt("R7", 1'b1);
    busWrite(8'h54, 16'h0002);
    expectRead("R6", 8'h54, 16'h0000);
    expectInt("R9", 1'b0);
    lolIn = 1'b0; step(3);

    phase = "R3";
    updDoneIn = '1; step(4);
    expectRead("R3", 8'h52, 16'h0000);
    updReqIn = 1'b1; updDoneIn = 4'b1101; step(4);
    expectRead("R3", 8'h52, 16'h0000);
    phase = "R2";
    updDoneIn = '1; step(3);
    expectRead("R2", 8'h52, 16'h0001);
    expectRead("R4", 8'h54, 16'h0001);
    updReqIn = 1'b0; step(3);
    expectRead("R3", 8'h52, 16'h0000);

    phase = "R5";
    rxClkAct = 1'b1; step(); rxClkAct = 1'b0; step(4);
    expectRead("R5", 8'h54, 16'h0081);
    txClkAct = 1'b1; step(); txClkAct = 1'b0; step(4);
    expectRead("R5", 8'h54, 16'h00C1);
    busWrite(8'h54, 16'hFFFF);
    expectRead("R6", 8'h54, 16'h0000);

    phase = "R11";
    drvFaultIn = 1'b1; step(5);
    busWrite(8'h58, 16'hFFFF);
    busWrite(8'h52, 16'hFFFF);
    expectRead("R11", 8'h54, 16'h0004);
    expectRead("R11", 8'h56, 16'h0002);
    expectRead("R11", 8'h58, 16'h0000);
    drvFaultIn = 1'b0; step(4);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule